// File: doc/BRIEF.md
# Parallel Video Timing Flag Recovery

This block produces horizontal, vertical and field timing flags for a 10-bit standard-definition parallel video stream. It has two sources for the flags. With the decode control low, the block takes H, V and F from external pins and passes them through. With it high, the block searches the incoming words for embedded timing reference sequences, checks the protection bits of each sequence's flag word, and derives H, V and F from the flag words it accepts.

When the flags are decoded, a shaping input selects the form of the H output. With the input low, H covers the whole horizontal blanking interval, from the first word of the end-of-active-video sequence to the last word of the start-of-active-video sequence. With the input high, H follows the H bit carried in each accepted flag word. The data word and its flags leave through registers with the same fixed four-cycle latency, so every output word carries its own flags. The decoder runs in both modes, so after a switch to decoding the flags already reflect the sequences seen while the pins were in use.

Top module: `trs_flag_recover`

## Requirements
- R1: `dout` equals the `din` word that was sampled four clock edges earlier. The flag outputs use the same four-edge latency and belong to that word.
- R2: With `trs_detect` low, `h_out`, `v_out` and `f_out` equal `h_in`, `v_in` and `f_in` from four edges earlier. `h_cfg` has no effect in this mode.
- R3: A timing sequence is the four words 3FFh, 000h, 000h, flag word. In the flag word, bit 9 must be 1, bit 8 is F, bit 7 is V and bit 6 is H. If bit 9 is 0, the sequence is ignored.
- R4: A flag word is accepted only if bits 5..2 equal {V^H, F^H, F^V, F^V^H}. A sequence whose protection bits do not match leaves every flag output as it would have been without that sequence, in both H shapes.
- R5: With `trs_detect` high and `h_cfg` high, `h_out` keeps its old value up to and including the flag word, and takes the new H value from the word that follows the flag word.
- R6: With `trs_detect` high, `v_out` and `f_out` take the new V and F values from the word after an accepted flag word. Between accepted sequences they hold their values.
- R7: With `trs_detect` high and `h_cfg` low, `h_out` rises on the 3FFh word of an accepted sequence with H=1. It stays high through the flag word of the next accepted sequence with H=0 and falls on the word after that. Every word of an accepted H=0 sequence carries `h_out` high.
- R8: While `rst_n` is low, `dout`, `h_out`, `v_out` and `f_out` are all 0.
- R9: The decoder tracks sequences whatever the mode. `trs_detect` and `h_cfg` act on the word that leaves at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trs_detect | input | 1 | 1: decode flags from embedded sequences; 0: use the external pins |
| h_cfg | input | 1 | H shape in decode mode: 0 covers the whole blanking interval, 1 follows the H bit |
| din | input | 10 | Parallel video word |
| h_in | input | 1 | External horizontal flag |
| v_in | input | 1 | External vertical flag |
| f_in | input | 1 | External field flag |
| dout | output | 10 | Video word, delayed to match the flags |
| h_out | output | 1 | Horizontal flag |
| v_out | output | 1 | Vertical flag |
| f_out | output | 1 | Field flag |

## Verification
The bench sends sequences that are back to back with no blanking words between them, so a design that clears its pending update or its blanking tail too early would misplace H or V by a word or more. It sends flag words with a corrupted protection bit and with bit 9 clear; a design that skipped either check would toggle H, V or F. It switches the mode and the H shape in the middle of a line; a design that stopped decoding while the pins were in use, or that latched the mode one word late, would show stale flags. It also checks the exact word on which H rises and falls in both shapes, which catches any off-by-one in the four-word lookahead.

// File: rtl/trs_flag_recover.sv
module trs_flag_recover #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trs_detect,
  input  logic          h_cfg,
  input  logic [DW-1:0] din,
  input  logic          h_in,
  input  logic          v_in,
  input  logic          f_in,
  output logic [DW-1:0] dout,
  output logic          h_out,
  output logic          v_out,
  output logic          f_out
);
  localparam int DEPTH = 4;
  localparam logic [DW-1:0] W_ONES = '1;
  localparam logic [DW-1:0] W_ZERO = '0;

  logic [DW-1:0] sr  [DEPTH];
  logic [2:0]    esr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        sr[i]  <= W_ZERO;
        esr[i] <= 3'b000;
      end
    end else begin
      sr[0]  <= din;
      esr[0] <= {f_in, v_in, h_in};
      for (int i = 1; i < DEPTH; i++) begin
        sr[i]  <= sr[i-1];
        esr[i] <= esr[i-1];
      end
    end
  end

  wire [DW-1:0] xyz = sr[0];
  wire xf = xyz[DW-2];
  wire xv = xyz[DW-3];
  wire xh = xyz[DW-4];
  wire hdr = (sr[3] == W_ONES) && (sr[2] == W_ZERO) && (sr[1] == W_ZERO);
  wire prot_ok = (xyz[DW-5:DW-8] == {xv ^ xh, xf ^ xh, xf ^ xv, xf ^ xv ^ xh});
  wire det = hdr && xyz[DW-1] && prot_ok;
  wire eav = det && xh;
  wire sav = det && !xh;

  logic       blank_q;
  logic [1:0] sav_cnt;
  logic [2:0] pend;
  logic       ph, pv, pf;
  logic       th, tv, tf;

  wire apply = (pend == 3'd1);
  wire h_al_n = det || (sav_cnt != 2'd0) || blank_q;
  wire th_n = apply ? ph : th;
  wire tv_n = apply ? pv : tv;
  wire tf_n = apply ? pf : tf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      sav_cnt <= 2'd0;
      pend    <= 3'd0;
      {ph, pv, pf} <= 3'b000;
      {th, tv, tf} <= 3'b000;
    end else begin
      if (eav) blank_q <= 1'b1;
      else if (sav) blank_q <= 1'b0;
      if (sav) sav_cnt <= 2'd3;
      else if (sav_cnt != 2'd0) sav_cnt <= sav_cnt - 2'd1;
      if (det) begin
        pend <= 3'd4;
        {ph, pv, pf} <= {xh, xv, xf};
      end else if (pend != 3'd0) begin
        pend <= pend - 3'd1;
      end
      {th, tv, tf} <= {th_n, tv_n, tf_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= W_ZERO;
      {h_out, v_out, f_out} <= 3'b000;
    end else begin
      dout <= sr[3];
      if (trs_detect) begin
        h_out <= h_cfg ? th_n : h_al_n;
        v_out <= tv_n;
        f_out <= tf_n;
      end else begin
        {f_out, v_out, h_out} <= esr[3];
      end
    end
  end

  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 3'd0;
    else if (age != 3'd5) age <= age + 3'd1;
  end

  assert_dout_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd5) |-> dout == $past(din, 5));

  assert_ext_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd5 && !$past(trs_detect)) |-> {h_out, v_out, f_out} == $past({h_in, v_in, f_in}, 5));

  assert_hdr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> (pend == 3'd4 && dout == W_ONES));

  assert_bad_prot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr && !prot_ok && pend == 3'd0) |=> pend == 3'd0);

  assert_trs_h_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trs_detect && h_cfg) && $past(trs_detect && h_cfg, 2) && h_out != $past(h_out))
      |-> $past(pend) == 3'd1);

  assert_vf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({tv, tf}) |-> $past(pend) == 3'd1);

  assert_sav_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_cnt != 2'd0 && $past(trs_detect && !h_cfg)) |-> h_out);
endmodule

// File: tb/sim_trs_flag_recover.sv
module sim_trs_flag_recover;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, trs_detect, h_cfg, h_in, v_in, f_in;
  logic [9:0] din, dout;
  logic h_out, v_out, f_out;

  trs_flag_recover u0 (
    .clk(clk), .rst_n(rst_n), .trs_detect(trs_detect), .h_cfg(h_cfg),
    .din(din), .h_in(h_in), .v_in(v_in), .f_in(f_in),
    .dout(dout), .h_out(h_out), .v_out(v_out), .f_out(f_out)
  );

  int hd [0:8191];
  bit hh [0:8191];
  bit hv [0:8191];
  bit hf [0:8191];
  bit hm [0:8191];
  bit hc [0:8191];
  int wr = 4;
  int rd = 0;
  int fillk = 0;

  bit blank = 0, vh = 0, vv = 0, vf = 0, ph = 0, pv = 0, pf = 0;
  int savrem = 0;
  int apply_at = -1;

  int compared = 0;
  int mism = 0;
  string phase = "R1";

  task automatic check1(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mism++;
      $display("FAIL %s [%s] word %0d: got %0h expected %0h", tag, phase, rd, got, exp);
    end
  endtask

  task automatic model_and_check();
    logic [9:0] x;
    bit hal, eh, ev, ef;
    int j;
    j = rd;
    if (apply_at == j) begin
      vh = ph; vv = pv; vf = pf;
    end
    if (hd[j] == 1023 && hd[j+1] == 0 && hd[j+2] == 0) begin
      x = hd[j+3][9:0];
      if (x[9] && x[5:2] == {x[7]^x[6], x[8]^x[6], x[8]^x[7], x[8]^x[7]^x[6]}) begin
        if (x[6]) blank = 1;
        else begin
          blank = 0;
          savrem = 4;
        end
        ph = x[6]; pv = x[7]; pf = x[8];
        apply_at = j + 4;
      end
    end
    hal = blank || (savrem > 0);
    if (savrem > 0) savrem--;
    if (hm[j+4]) begin
      eh = hc[j+4] ? vh : hal;
      ev = vv;
      ef = vf;
    end else begin
      eh = hh[j]; ev = hv[j]; ef = hf[j];
    end
    check1("R1 dout", int'(dout), hd[j]);
    check1(!hm[j+4] ? "R2 h" : (hc[j+4] ? "R5 h" : "R7 h"), int'(h_out), int'(eh));
    check1(!hm[j+4] ? "R2 v" : "R6 v", int'(v_out), int'(ev));
    check1(!hm[j+4] ? "R2 f" : "R6 f", int'(f_out), int'(ef));
    rd++;
  endtask

  task automatic step(input logic [9:0] d, input bit h, input bit v, input bit f);
    din = d; h_in = h; v_in = v; f_in = f;
    hd[wr] = int'(d); hh[wr] = h; hv[wr] = v; hf[wr] = f;
    hm[wr] = trs_detect; hc[wr] = h_cfg;
    wr++;
    @(posedge clk);
    #2;
    model_and_check();
    @(negedge clk);
  endtask

  function automatic logic [9:0] flagword(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic trs(bit f, bit v, bit h, int kind);
    logic [9:0] x;
    x = flagword(f, v, h);
    if (kind == 1) x[2] = ~x[2];
    if (kind == 2) x[9] = 1'b0;
    step(10'h3FF, 1'($urandom), 1'($urandom), 1'($urandom));
    step(10'h000, 1'($urandom), 1'($urandom), 1'($urandom));
    step(10'h000, 1'($urandom), 1'($urandom), 1'($urandom));
    step(x, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) begin
      step(10'(64 + (fillk * 37) % 900), 1'($urandom), 1'($urandom), 1'($urandom));
      fillk++;
    end
  endtask

  task automatic line(bit f, bit v);
    trs(f, v, 1, 0);
    fill(8);
    trs(f, v, 0, 0);
    fill(20);
  endtask

  initial begin
    #(200000 * 10);
    mism++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      hd[i] = 0; hh[i] = 0; hv[i] = 0; hf[i] = 0; hm[i] = 0; hc[i] = 0;
    end
    rst_n = 1'b0; trs_detect = 1'b1; h_cfg = 1'b0;
    din = 10'h155; h_in = 1'b1; v_in = 1'b1; f_in = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    phase = "R8 reset";
    check1("R8 dout", int'(dout), 0);
    check1("R8 flags", int'({h_out, v_out, f_out}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    phase = "R7 active-line H";
    fill(6);
    line(0, 0); line(0, 1); line(1, 1); line(1, 0);

    phase = "R5 TRS-bit H";
    h_cfg = 1'b1;
    line(0, 0); line(0, 1); line(1, 0);

    phase = "R4 bad protection";
    trs(1, 1, 1, 1); fill(6); trs(1, 1, 0, 1); fill(6);
    h_cfg = 1'b0;
    trs(0, 1, 1, 1); fill(6); trs(0, 0, 0, 1); fill(6);

    phase = "R3 flag word bit 9 clear";
    trs(1, 1, 1, 2); fill(6);
    h_cfg = 1'b1;
    trs(0, 0, 1, 2); fill(6);

    phase = "R6 back-to-back sequences";
    trs(1, 1, 1, 0); trs(0, 1, 0, 0); trs(1, 0, 1, 0); fill(3);
    h_cfg = 1'b0;
    trs(0, 0, 1, 0); trs(1, 1, 0, 0); trs(0, 1, 1, 0); trs(0, 0, 0, 0); fill(5);

    phase = "R2 external pins";
    trs_detect = 1'b0;
    fill(10); h_cfg = 1'b1; line(1, 0); h_cfg = 1'b0; line(0, 1);

    phase = "R9 mode switch";
    trs(1, 0, 1, 0); fill(2);
    trs_detect = 1'b1; fill(3);
    h_cfg = 1'b1; trs(1, 1, 0, 0);
    trs_detect = 1'b0; fill(1);
    trs_detect = 1'b1; fill(2);
    h_cfg = 1'b0; fill(2);
    trs(0, 0, 1, 0);
    h_cfg = 1'b1; fill(2);
    h_cfg = 1'b0; fill(8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule